// File: doc/BRIEF.md
# Persistent Victim Store with Guarded Release

This block is a small fully associative store that sits behind the last-level cache and catches dirty lines that belong to the persistent address range. A caught line is never written to its home address by this block. It stays in the store and answers later read misses for that address. Each entry keeps a valid bit, the line address, the data word and the token of the transaction that wrote it last.

A background copy engine writes committed log records to their home locations. When it has written an address home, it issues a release. The entry is removed only if the release is safe. A release is safe when its token matches the last writer. With the value guard enabled, a release is also safe when its value equals the stored value. A newer write to the same address therefore survives a stale release.

A flush command empties the store, as a restart does. If an evicted line finds no free slot, the store raises a sticky overflow flag. Upstream logic must then fall back to a slower path that searches the log. The line is not silently lost.

Top module: `pvc_victim_store`

## Requirements
- R1: After reset every lookup misses and the overflow flag is 0.
- R2: An evict to an address not present stores address, data and token in the lowest-numbered free slot. From the next cycle a lookup of that address reports hit=1 with the evicted data, in the same cycle as the lookup request.
- R3: An evict to an address already present overwrites its data and token in place. It takes no second slot, so at most one entry matches any address.
- R4: A lookup of an absent address reports hit=0 and data=0.
- R5: A release whose token equals the stored token deletes the entry. Later lookups of that address miss.
- R6: A release whose token differs from the stored token, with a value that also differs, leaves the entry and its data unchanged.
- R7: With the value guard enabled (parameter VALUE_GUARD=1, the default), a release with a different token but a value equal to the stored data deletes the entry.
- R8: A release of an address that is not present changes nothing.
- R9: When an evict and a release name the same address in one cycle, the evict wins. The entry remains and holds the evicted data and token.
- R10: A flush invalidates every entry and clears the overflow flag. An evict in the same cycle as a flush is discarded.
- R11: An evict of a new address while all DEPTH slots are valid sets the overflow flag one cycle later and alters no entry. The flag stays set until a flush.
- R12: DEPTH distinct addresses fit without raising the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_vld | input | 1 | Evicted persistent line present |
| ev_addr | input | ADDR_W | Address of the evicted line |
| ev_data | input | DATA_W | Data of the evicted line |
| ev_tok | input | TOK_W | Token of the transaction that wrote it |
| lk_vld | input | 1 | Read-miss lookup request |
| lk_addr | input | ADDR_W | Lookup address |
| lk_hit | output | 1 | Lookup found the address (combinational) |
| lk_data | output | DATA_W | Stored data on a hit, zero otherwise |
| rel_vld | input | 1 | Copy engine wrote an address home |
| rel_addr | input | ADDR_W | Released address |
| rel_tok | input | TOK_W | Token of the releasing transaction |
| rel_data | input | DATA_W | Value the copy engine wrote home |
| flush | input | 1 | Invalidate all entries and clear overflow |
| ovf | output | 1 | Sticky degraded-mode flag: an evicted line found no slot |

## Verification
The bench targets stale releases. A store that checked only the address would drop the newer value after an older transaction's release. A store that ignored the value guard would keep a line that equal-value releases should free. It also collides an evict with a release on the same address in one cycle; a wrong priority would lose that fresh line. It fills every slot, then rewrites one address and pushes one address too many. A store that allocated duplicate entries would overflow early. One that overwrote a slot when full would corrupt an old line instead of raising the flag. Finally, a flush arriving together with an evict must leave the store completely empty.

// File: rtl/pvc_pkg.sv
package pvc_pkg;

    // Outcome of a release request against the current table.
    typedef enum logic [1:0] {
        REL_IDLE = 2'd0,
        REL_KEEP = 2'd1,
        REL_DROP = 2'd2
    } rel_act_e;

endpackage

// File: rtl/pvc_cam_match.sv
module pvc_cam_match #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]             vld,
    input  logic [DEPTH-1:0][ADDR_W-1:0] tab,
    input  logic [ADDR_W-1:0]            key,
    output logic [DEPTH-1:0]             hit_vec,
    output logic                         hit,
    output logic [IDX_W-1:0]             idx
);

    // One comparator per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (tab[g] == key);
    end

    assign hit = |hit_vec;

    always_comb begin
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/pvc_free_pick.sv
module pvc_free_pick #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] vld,
    output logic             any_free,
    output logic [IDX_W-1:0] free_idx
);

    assign any_free = ~&vld;

    // Lowest-numbered empty slot wins.
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/pvc_rel_guard.sv
module pvc_rel_guard
    import pvc_pkg::*;
#(
    parameter int TOK_W       = 8,
    parameter int DATA_W      = 32,
    parameter bit VALUE_GUARD = 1'b1
) (
    input  logic              req,
    input  logic              present,
    input  logic [TOK_W-1:0]  own_tok,
    input  logic [DATA_W-1:0] own_data,
    input  logic [TOK_W-1:0]  rel_tok,
    input  logic [DATA_W-1:0] rel_data,
    output rel_act_e          act
);

    logic tok_same;
    logic val_same;

    assign tok_same = (own_tok == rel_tok);

    if (VALUE_GUARD) begin : g_val
        assign val_same = (own_data == rel_data);
    end else begin : g_tok_only
        assign val_same = 1'b0;
    end

    always_comb begin
        if (!req || !present)        act = REL_IDLE;
        else if (tok_same || val_same) act = REL_DROP;
        else                         act = REL_KEEP;
    end

endmodule

// File: rtl/pvc_victim_store.sv
module pvc_victim_store
    import pvc_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int TOK_W       = 8,
    parameter bit VALUE_GUARD = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_vld,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic [TOK_W-1:0]  ev_tok,
    input  logic              lk_vld,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              rel_vld,
    input  logic [ADDR_W-1:0] rel_addr,
    input  logic [TOK_W-1:0]  rel_tok,
    input  logic [DATA_W-1:0] rel_data,
    input  logic              flush,
    output logic              ovf
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0][TOK_W-1:0]  tok;
        logic                         ovf;
    } store_t;

    store_t st_d, st_q;

    // Address searches on the registered table.
    logic [DEPTH-1:0] lk_vec, ev_vec, rel_vec;
    logic             lk_any, ev_any, rel_any;
    logic [IDX_W-1:0] lk_idx, ev_idx, rel_idx;
    logic             slot_free;
    logic [IDX_W-1:0] slot_idx;
    rel_act_e         rel_act;
    logic             same_addr;

    pvc_cam_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_lk_cam (
        .vld(st_q.vld), .tab(st_q.addr), .key(lk_addr),
        .hit_vec(lk_vec), .hit(lk_any), .idx(lk_idx)
    );

    pvc_cam_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ev_cam (
        .vld(st_q.vld), .tab(st_q.addr), .key(ev_addr),
        .hit_vec(ev_vec), .hit(ev_any), .idx(ev_idx)
    );

    pvc_cam_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rel_cam (
        .vld(st_q.vld), .tab(st_q.addr), .key(rel_addr),
        .hit_vec(rel_vec), .hit(rel_any), .idx(rel_idx)
    );

    pvc_free_pick #(.DEPTH(DEPTH)) u_free (
        .vld(st_q.vld), .any_free(slot_free), .free_idx(slot_idx)
    );

    pvc_rel_guard #(.TOK_W(TOK_W), .DATA_W(DATA_W), .VALUE_GUARD(VALUE_GUARD)) u_guard (
        .req(rel_vld), .present(rel_any),
        .own_tok(st_q.tok[rel_idx]), .own_data(st_q.data[rel_idx]),
        .rel_tok(rel_tok), .rel_data(rel_data),
        .act(rel_act)
    );

    assign same_addr = ev_vld && rel_vld && (ev_addr == rel_addr);

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.vld = '0;
            st_d.ovf = 1'b0;
        end else begin
            // Guarded release; a concurrent evict of the same line wins.
            if (rel_act == REL_DROP && !same_addr) begin
                st_d.vld[rel_idx] = 1'b0;
            end
            if (ev_vld) begin
                if (ev_any) begin
                    st_d.data[ev_idx] = ev_data;
                    st_d.tok[ev_idx]  = ev_tok;
                end else if (slot_free) begin
                    st_d.vld[slot_idx]  = 1'b1;
                    st_d.addr[slot_idx] = ev_addr;
                    st_d.data[slot_idx] = ev_data;
                    st_d.tok[slot_idx]  = ev_tok;
                end else begin
                    st_d.ovf = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld  <= '0;
            st_q.addr <= '0;
            st_q.data <= '0;
            st_q.tok  <= '0;
            st_q.ovf  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lk_hit  = lk_vld && lk_any;
    assign lk_data = lk_hit ? st_q.data[lk_idx] : '0;
    assign ovf     = st_q.ovf;

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec)); // R3

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_data == '0)); // R4

    AST_FULL_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vld && !flush && !ev_any && (&st_q.vld)) |=> ovf); // R11

    AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flush) |=> ovf); // R11

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.vld == '0) && !ovf); // R10

    AST_EVICT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (same_addr && !flush) |=> ($countones(st_q.vld) >= $countones($past(st_q.vld)))); // R9

endmodule

// File: tb/sim_pvc_victim_store.sv
module sim_pvc_victim_store;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_vld = 1'b0;
    logic [AW-1:0] ev_addr = '0;
    logic [DW-1:0] ev_data = '0;
    logic [TW-1:0] ev_tok = '0;
    logic          lk_vld = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_hit;
    logic [DW-1:0] lk_data;
    logic          rel_vld = 1'b0;
    logic [AW-1:0] rel_addr = '0;
    logic [TW-1:0] rel_tok = '0;
    logic [DW-1:0] rel_data = '0;
    logic          flush = 1'b0;
    logic          ovf;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pvc_victim_store u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_vld(ev_vld), .ev_addr(ev_addr), .ev_data(ev_data), .ev_tok(ev_tok),
        .lk_vld(lk_vld), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
        .rel_vld(rel_vld), .rel_addr(rel_addr), .rel_tok(rel_tok), .rel_data(rel_data),
        .flush(flush), .ovf(ovf)
    );

    // Vector: op[46:45] addr[44:37] data[36:21] tok[20:17] hit[16] exp[15:0]
    // op 0 evict, 1 release, 2 lookup check
    localparam int NV = 14;
    localparam logic [46:0] VEC [NV] = '{
        {2'd2, 8'h10, 16'h0000, 4'd0, 1'b0, 16'h0000}, // R4 miss
        {2'd0, 8'h10, 16'h1111, 4'd1, 1'b0, 16'h0000},
        {2'd2, 8'h10, 16'h0000, 4'd0, 1'b1, 16'h1111}, // R2
        {2'd0, 8'h10, 16'h2222, 4'd2, 1'b0, 16'h0000},
        {2'd2, 8'h10, 16'h0000, 4'd0, 1'b1, 16'h2222}, // R3
        {2'd1, 8'h10, 16'h1111, 4'd1, 1'b0, 16'h0000},
        {2'd2, 8'h10, 16'h0000, 4'd0, 1'b1, 16'h2222}, // R6
        {2'd1, 8'h10, 16'h2222, 4'd3, 1'b0, 16'h0000},
        {2'd2, 8'h10, 16'h0000, 4'd0, 1'b0, 16'h0000}, // R7
        {2'd0, 8'h20, 16'h3333, 4'd4, 1'b0, 16'h0000},
        {2'd1, 8'h20, 16'h0000, 4'd4, 1'b0, 16'h0000},
        {2'd2, 8'h20, 16'h0000, 4'd0, 1'b0, 16'h0000}, // R5
        {2'd1, 8'h30, 16'h0000, 4'd1, 1'b0, 16'h0000},
        {2'd2, 8'h30, 16'h0000, 4'd0, 1'b0, 16'h0000}  // R8
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        ev_vld = 1'b0; rel_vld = 1'b0; flush = 1'b0;
    endtask

    task automatic evict(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [TW-1:0] t);
        ev_vld = 1'b1; ev_addr = a; ev_data = d; ev_tok = t;
    endtask

    task automatic release_line(input logic [AW-1:0] a, input logic [TW-1:0] t, input logic [DW-1:0] d);
        rel_vld = 1'b1; rel_addr = a; rel_tok = t; rel_data = d;
    endtask

    task automatic look(input string req, input logic [AW-1:0] a, input logic h, input logic [DW-1:0] d);
        lk_vld = 1'b1; lk_addr = a;
        #1;
        chk(req, {31'b0, lk_hit}, {31'b0, h});
        chk(req, lk_data, d);
        lk_vld = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        look("R1", 16'h0010, 1'b0, '0);
        chk("R1", {31'b0, ovf}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [46:0] v;
            v = VEC[i];
            case (v[46:45])
                2'd0: begin evict({8'h0, v[44:37]}, {16'h0, v[36:21]}, {4'h0, v[20:17]}); tick(); end
                2'd1: begin release_line({8'h0, v[44:37]}, {4'h0, v[20:17]}, {16'h0, v[36:21]}); tick(); end
                default: look("R2-vector", {8'h0, v[44:37]}, v[16], {16'h0, v[15:0]});
            endcase
        end

        // R9: evict and release on the same address in one cycle
        evict(16'h0040, 32'hAAAA, 8'd5); tick();
        evict(16'h0040, 32'hBBBB, 8'd6);
        release_line(16'h0040, 8'd5, 32'hAAAA);
        tick();
        look("R9", 16'h0040, 1'b1, 32'hBBBB);

        // R12: fill to capacity (0x40 already holds one slot)
        for (int i = 1; i < 8; i++) begin
            evict(16'h0100 + 16'(i), 32'h5000 + 32'(i), 8'd7); tick();
        end
        chk("R12", {31'b0, ovf}, 32'd0);
        // R3: rewrite of a present address takes no new slot
        evict(16'h0103, 32'h7777, 8'd8); tick();
        chk("R3", {31'b0, ovf}, 32'd0);
        look("R3", 16'h0103, 1'b1, 32'h7777);

        // R11: one too many
        evict(16'h0200, 32'hDEAD, 8'd9); tick();
        chk("R11", {31'b0, ovf}, 32'd1);
        look("R11", 16'h0200, 1'b0, '0);
        look("R11", 16'h0101, 1'b1, 32'h5001);
        look("R11", 16'h0040, 1'b1, 32'hBBBB);
        release_line(16'h0101, 8'd7, 32'h0); tick();
        chk("R11", {31'b0, ovf}, 32'd1);

        // R10: flush beats a concurrent evict
        flush = 1'b1;
        evict(16'h0300, 32'h1234, 8'd1);
        tick();
        chk("R10", {31'b0, ovf}, 32'd0);
        look("R10", 16'h0300, 1'b0, '0);
        look("R10", 16'h0040, 1'b0, '0);
        look("R10", 16'h0107, 1'b0, '0);

        // R2 after flush: slot reuse
        evict(16'h0400, 32'h4444, 8'd2); tick();
        look("R2", 16'h0400, 1'b1, 32'h4444);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

endmodule